// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns the system clock into two timing pulses for a serial port: an oversample tick at sixteen times the bit rate, and a bit tick that fires once for every sixteen oversample ticks. The rate is set by a divisor made of a 16-bit whole part and a 6-bit fraction counted in sixty-fourths. The divisor is the system clock frequency divided by sixteen times the wanted bit rate. For example, a 50 MHz clock with whole part 27 and fraction 8 gives about 115207 bit/s.

Software writes the whole part, the fraction and an 8-bit line setting through a one-cycle register write port. The whole part and the fraction are only staged by their own writes. A write of the line setting copies the staged divisor and the new line setting into one 30-bit active register in a single step. The running rate therefore changes only at that step. The fraction is applied by a 6-bit phase accumulator. Each oversample period lasts the whole-part count of clocks. One extra clock is added whenever the accumulator carries. An enable input holds all counters cleared while it is low.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the outputs `osTick` and `bitTick` are low and `lineCtl` is 0. The active divisor is 0, so no tick appears even while `uartEn` is high.
- R2: A write to address 0 (whole part, `wrData[15:0]`) or address 1 (fraction, `wrData[5:0]`) leaves the running tick period unchanged until the next write to address 2.
- R3: A write to address 2 loads the staged whole part, the staged fraction and `wrData[7:0]` into the active register together. `lineCtl` shows the new value in the cycle after the write.
- R4: With an active whole part W of at least 2 and a fraction F, each oversample period lasts W or W+1 clocks. Any 64 consecutive periods last exactly 64·W+F clocks.
- R5: Over 1024 consecutive oversample periods from enable, the total is exactly 1024·W+16·F clocks.
- R6: `bitTick` is high only together with `osTick`, on every 16th oversample tick counted from enable.
- R7: While `uartEn` is low, both ticks are low from the next cycle on and the divider is cleared. After `uartEn` rises, the first `osTick` appears W clock edges later.
- R8: An active whole part of 0 produces no ticks.
- R9: With an active whole part of 1, the fraction is ignored and `osTick` is high in every cycle.
- R10: A write to address 3 has no effect. `lineCtl` and the tick period stay as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrAddr | input | 2 | 0 whole part, 1 fraction, 2 line setting (commits), 3 unused |
| wrData | input | 16 | Write data, low bits used for the fraction and the line setting |
| uartEn | input | 1 | Enables tick generation when high |
| osTick | output | 1 | One-cycle oversample tick at 16x the bit rate |
| bitTick | output | 1 | One-cycle bit-rate tick |
| lineCtl | output | 8 | Active line setting: [1:0] word length minus 5, [2] parity on, [3] even parity, [4] two stop bits, [5] FIFO on |

## Verification
The bench builds the block with its default parameters: a 16-bit whole part, a 6-bit fraction, an 8-bit line setting and a ratio of sixteen between the two ticks. With these values the fraction values 0, 1, 8 and 63 can be measured as exact clock totals over 1024 periods. Carry patterns from sparse to nearly every period are covered. The whole-part corner values 0 and 1 are reachable, and so is the bit-tick alignment across 64 bit periods.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

  // Register select codes on the write port
  typedef enum logic [1:0] {
    SEL_WHOLE = 2'd0,
    SEL_FRAC  = 2'd1,
    SEL_LINE  = 2'd2,
    SEL_NONE  = 2'd3
  } regSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic ldWhole;   // stage a new whole part
    logic ldFrac;    // stage a new fraction
    logic ldLine;    // commit staged divisor plus line setting
    logic run;       // divider may count
    logic wholeOnly; // fraction must be ignored (whole part of one)
  } divStrobe_t;

endpackage

// File: rtl/baud_ctrl.sv
module baud_ctrl
  import baud_tick_pkg::*;
#(
  parameter int INT_W = 16
) (
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic             uartEn,
  input  logic [INT_W-1:0] actWhole,
  output divStrobe_t       strb
);

  regSel_e sel;
  logic    wholeZero;
  logic    wholeUnit;

  assign sel       = regSel_e'(wrAddr);
  assign wholeZero = (actWhole == '0);
  assign wholeUnit = (actWhole == INT_W'(1));

  always_comb begin
    strb = '0;
    if (wrEn) begin
      unique case (sel)
        SEL_WHOLE: strb.ldWhole = 1'b1;
        SEL_FRAC:  strb.ldFrac  = 1'b1;
        SEL_LINE:  strb.ldLine  = 1'b1;
        SEL_NONE:  ;
      endcase
    end
    // A zero whole part stops the divider outright
    strb.run       = uartEn && !wholeZero;
    strb.wholeOnly = wholeUnit;
  end

endmodule

// File: rtl/baud_dp.sv
module baud_dp
  import baud_tick_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6,
  parameter int LINE_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  divStrobe_t        strb,
  input  logic [INT_W-1:0]  wrData,
  output logic [INT_W-1:0]  actWhole,
  output logic [LINE_W-1:0] lineCtl,
  output logic              osTick,
  output logic              bitTick
);

  localparam int SUB_W = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int CNT_W = INT_W + 1;

  // Staged and active divisor
  logic [INT_W-1:0]  stgWhole;
  logic [FRAC_W-1:0] stgFrac;
  logic [FRAC_W-1:0] actFrac;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stgWhole <= '0;
      stgFrac  <= '0;
      actWhole <= '0;
      actFrac  <= '0;
      lineCtl  <= '0;
    end else begin
      if (strb.ldWhole) stgWhole <= wrData;
      if (strb.ldFrac)  stgFrac  <= wrData[FRAC_W-1:0];
      if (strb.ldLine) begin
        actWhole <= stgWhole;
        actFrac  <= stgFrac;
        lineCtl  <= wrData[LINE_W-1:0];
      end
    end
  end

  // Phase accumulator and period counter
  logic [FRAC_W-1:0] fracEff;
  logic [FRAC_W:0]   accSum;
  logic [FRAC_W-1:0] acc;
  logic              carry;
  logic [CNT_W-1:0]  limit;
  logic [CNT_W-1:0]  cnt;
  logic              periodEnd;
  logic [SUB_W-1:0]  subCnt;
  logic [SUB_W-1:0]  subNext;
  logic              subWrap;

  assign fracEff   = strb.wholeOnly ? '0 : actFrac;
  assign accSum    = {1'b0, acc} + {1'b0, fracEff};
  assign carry     = accSum[FRAC_W];
  assign limit     = {1'b0, actWhole} + {{INT_W{1'b0}}, carry} - CNT_W'(1);
  // Greater-or-equal lets a shortened divisor end a long period at once
  assign periodEnd = strb.run && (cnt >= limit);

  generate
    if ((OSR & (OSR - 1)) == 0) begin : g_pow2
      assign subWrap = (subCnt == {SUB_W{1'b1}});
      assign subNext = subCnt + SUB_W'(1);
    end else begin : g_any
      assign subWrap = (subCnt == SUB_W'(OSR - 1));
      assign subNext = subWrap ? '0 : subCnt + SUB_W'(1);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      acc     <= '0;
      subCnt  <= '0;
      osTick  <= 1'b0;
      bitTick <= 1'b0;
    end else if (!strb.run) begin
      cnt     <= '0;
      acc     <= '0;
      subCnt  <= '0;
      osTick  <= 1'b0;
      bitTick <= 1'b0;
    end else begin
      osTick  <= periodEnd;
      bitTick <= periodEnd && subWrap;
      if (periodEnd) begin
        cnt    <= '0;
        acc    <= accSum[FRAC_W-1:0];
        subCnt <= subNext;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6,
  parameter int LINE_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [INT_W-1:0]  wrData,
  input  logic              uartEn,
  output logic              osTick,
  output logic              bitTick,
  output logic [LINE_W-1:0] lineCtl
);

  divStrobe_t       strb;
  logic [INT_W-1:0] actWhole;

  baud_ctrl #(.INT_W(INT_W)) u_ctrl (
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .uartEn   (uartEn),
    .actWhole (actWhole),
    .strb     (strb)
  );

  baud_dp #(
    .INT_W  (INT_W),
    .FRAC_W (FRAC_W),
    .LINE_W (LINE_W),
    .OSR    (OSR)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .actWhole (actWhole),
    .lineCtl  (lineCtl),
    .osTick   (osTick),
    .bitTick  (bitTick)
  );

endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk #(
  parameter int INT_W  = 16,
  parameter int LINE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [1:0]        wrAddr,
  input logic [LINE_W-1:0] wrLine,
  input logic              uartEn,
  input logic [INT_W-1:0]  actWhole,
  input logic              osTick,
  input logic              bitTick,
  input logic [LINE_W-1:0] lineCtl
);

  logic [INT_W+1:0] gapCnt;
  logic             armed;
  logic             lineWr;

  assign lineWr = wrEn && (wrAddr == 2'd2);

  // Clocks since the last oversample tick; armed once a full clean period starts
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
      armed  <= 1'b0;
    end else begin
      if (osTick) gapCnt <= {{(INT_W+1){1'b0}}, 1'b1};
      else if (gapCnt != '1) gapCnt <= gapCnt + 1'b1;
      if (lineWr || !uartEn) armed <= 1'b0;
      else if (osTick)       armed <= 1'b1;
    end
  end

  p_period_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    (osTick && armed && actWhole >= INT_W'(2)) |->
      (gapCnt == {2'b00, actWhole} || gapCnt == {2'b00, actWhole} + 1'b1));

  p_bit_with_os_r6: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> osTick);

  p_quiet_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    !uartEn |=> (!osTick && !bitTick));

  p_zero_div_r8: assert property (@(posedge clk) disable iff (!rstN)
    (actWhole == '0) |=> !osTick);

  p_unit_div_r9: assert property (@(posedge clk) disable iff (!rstN)
    (uartEn && actWhole == INT_W'(1) && $past(uartEn && actWhole == INT_W'(1))) |-> osTick);

  p_line_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    lineWr |=> (lineCtl == $past(wrLine)));

  p_line_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !lineWr |=> $stable(lineCtl));

endmodule

bind baud_tick_gen baud_tick_chk #(.INT_W(INT_W), .LINE_W(LINE_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .wrLine   (wrData[LINE_W-1:0]),
  .uartEn   (uartEn),
  .actWhole (actWhole),
  .osTick   (osTick),
  .bitTick  (bitTick),
  .lineCtl  (lineCtl)
);

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [15:0] wrData = 16'd0;
  logic        uartEn = 1'b0;
  logic        osTick;
  logic        bitTick;
  logic [7:0]  lineCtl;

  int vectors = 0;
  int errs    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_tick_gen u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .uartEn  (uartEn),
    .osTick  (osTick),
    .bitTick (bitTick),
    .lineCtl (lineCtl)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = 16'd0;
  endtask

  // Count clock edges until osTick is seen high at a falling edge
  task automatic waitTick(output int edges);
    edges = 0;
    do begin
      @(negedge clk);
      edges++;
    end while (!osTick);
  endtask

  // From the current tick, sum the lengths of n further periods
  task automatic spanOf(input int n, output longint total);
    int e;
    total = 0;
    for (int i = 0; i < n; i++) begin
      waitTick(e);
      total += e;
    end
  endtask

  task automatic test_reset();
    chk(osTick == 1'b0 && bitTick == 1'b0, "R1", "ticks after reset", osTick, 0);
    chk(lineCtl == 8'd0, "R1", "lineCtl after reset", lineCtl, 0);
    @(negedge clk);
    uartEn = 1'b1;
    begin
      int seen = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (osTick || bitTick) seen++;
      end
      chk(seen == 0, "R1", "ticks with zero active divisor", seen, 0);
    end
    uartEn = 1'b0;
  endtask

  task automatic test_total(input int w, input int f, input logic [7:0] lc);
    int first, e, gapBad, bitBad, bitCnt;
    longint total;
    uartEn = 1'b0;
    wr(2'd0, 16'(w));
    wr(2'd1, 16'(f));
    wr(2'd2, {8'd0, lc});
    chk(lineCtl == lc, "R3", "lineCtl after commit", lineCtl, lc);
    @(negedge clk);
    uartEn = 1'b1;
    waitTick(first);
    chk(first == w, "R7", "edges from enable to first tick", first, w);
    gapBad = 0; bitBad = 0; bitCnt = 0; total = 0;
    if (bitTick) bitBad++;
    for (int i = 2; i <= 1025; i++) begin
      waitTick(e);
      total += e;
      if (e != w && e != w + 1) gapBad++;
      if (bitTick) bitCnt++;
      if (bitTick != ((i % 16) == 0)) bitBad++;
    end
    chk(gapBad == 0, "R4", "periods outside W..W+1", gapBad, 0);
    chk(total == 1024 * w + 16 * f, "R5", "clocks over 1024 periods", total, 1024 * w + 16 * f);
    chk(bitBad == 0 && bitCnt == 64, "R6", "bit tick placement/count", bitCnt, 64);
  endtask

  task automatic test_staged();
    int e;
    longint total;
    // Running at whole 4, fraction 0 from the previous scenario
    wr(2'd0, 16'd9);
    wr(2'd1, 16'd10);
    waitTick(e);
    spanOf(64, total);
    chk(total == 256, "R2", "period unchanged by staged writes", total, 256);
    wr(2'd2, 16'h0015);
    chk(lineCtl == 8'h15, "R3", "lineCtl after commit", lineCtl, 8'h15);
    waitTick(e);
    spanOf(64, total);
    chk(total == 64 * 9 + 10, "R4", "64 periods after commit", total, 64 * 9 + 10);
  endtask

  task automatic test_gate();
    int seen, first;
    @(negedge clk);
    uartEn = 1'b0;
    seen = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (osTick || bitTick) seen++;
    end
    chk(seen == 0, "R7", "ticks while disabled", seen, 0);
    uartEn = 1'b1;
    waitTick(first);
    chk(first == 9, "R7", "restart latency", first, 9);
  endtask

  task automatic test_ignore();
    int e;
    longint total;
    wr(2'd3, 16'h00AB);
    chk(lineCtl == 8'h15, "R10", "lineCtl after unused-address write", lineCtl, 8'h15);
    waitTick(e);
    spanOf(64, total);
    chk(total == 64 * 9 + 10, "R10", "period after unused-address write", total, 64 * 9 + 10);
  endtask

  task automatic test_unit();
    int high, bits;
    wr(2'd0, 16'd1);
    wr(2'd1, 16'd5);
    wr(2'd2, 16'h0003);
    @(negedge clk);
    high = 0; bits = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (osTick) high++;
      if (bitTick) bits++;
    end
    chk(high == 32, "R9", "tick every clock at whole part 1", high, 32);
    chk(bits == 2, "R6", "bit ticks in 32 oversample ticks", bits, 2);
  endtask

  task automatic test_zero();
    int seen;
    wr(2'd0, 16'd0);
    wr(2'd2, 16'h0003);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (osTick) seen++;
    end
    chk(seen == 0, "R8", "ticks at whole part 0", seen, 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    vectors++;
    errs++;
    $display("FAIL watchdog R1..: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_total(27, 8, 8'h23);
    test_total(3, 63, 8'h07);
    test_total(5, 1, 8'h11);
    test_total(4, 0, 8'h03);
    test_staged();
    test_gate();
    test_ignore();
    test_unit();
    test_zero();
    uartEn = 1'b0;
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule